// File: doc/BRIEF.md
# Staged Microword Loader

This block loads a 256-entry, 64-bit microcode store from a 16-bit host register bus. The host cannot write a whole microword at once. It first writes four 16-bit staging lanes. It then performs one write into a commit window. The address of that write picks the store entry, and its data value is discarded. The four staged lanes, concatenated, become the new contents of that entry.

Commits are only accepted while the block is in load mode. The host enters load mode by writing a fixed key value to the control register. A small two-state machine tracks the mode.
- `ST_IDLE`: commits are ignored. Writing the key moves the machine to `ST_LOAD`. Any other control write keeps it in `ST_IDLE`.
- `ST_LOAD`: commits inside the store range write the store. Commits past the last entry set a sticky flag instead. Writing the key again keeps the machine in `ST_LOAD`. Any other control write returns it to `ST_IDLE`.

The execution side reads whole microwords through a separate index port. Each read has a latency of one clock.

Address map (byte addresses on the host bus, all parameters):
- The control register is at `0x0208`.
- The staging lanes are at `0x0200`, `0x0202`, `0x0204` and `0x0206`.
- The commit window starts at `0x1400` and spans 1024 bytes.

Top module: `microstore_loader`

## Requirements
- R1: After reset, the control register reads 0x0000 and all four staging lanes read 0x0000.
- R2: A host write to staging lane k (byte address 0x0200 + 2k, k = 0..3) stores the 16-bit data. Reading that address returns it. The other lanes are unaffected.
- R3: Writing 0x0003 to the control register (0x0208) enters load mode, and control bit 0 then reads 1. Writing any other value leaves or stays out of load mode, and bit 0 reads 0.
- R4: In load mode, a write to byte address 0x1400 + 2i (i = 0..255) stores the staged microword into entry i. Lane 0 goes to bits 63:48, lane 1 to 47:32, lane 2 to 31:16 and lane 3 to 15:0.
- R5: The data value on the commit write has no effect on what is stored.
- R6: A commit-window write outside load mode leaves every store entry unchanged.
- R7: A commit leaves the staging lanes unchanged. Rewriting one lane and committing again stores the retained lanes together with the new one.
- R8: In load mode, a commit-window write at index 256..511 changes no entry. It sets control bit 15, which stays set through mode changes until reset.
- R9: `exe_word` shows entry `exe_idx` one clock after the index is presented. If that entry is committed in the same cycle, the old contents are returned.
- R10: A complete sequence of 256 words, each written as four staging writes followed by a commit, makes every entry readable with its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_we | input | 1 | Host write strobe, one write per cycle |
| host_rdata | output | 16 | Combinational read data for the control register and staging lanes; 0 elsewhere |
| exe_idx | input | 8 | Execution-side entry index |
| exe_word | output | 64 | Registered microword for the index of the previous cycle |

## Verification
A commit and an execution-side read of the same entry can land on the same clock edge. The bench provokes this by driving the commit-window write for entry i and `exe_idx = i` in the same cycle, with staged data that differs from the stored word. It judges the result in two steps. On the following cycle `exe_word` must still show the previous word. One cycle later, a read must show the newly staged word.

// File: rtl/mls_pkg.sv
package mls_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } mls_state_t;
endpackage

// File: rtl/mls_decode.sv
module mls_decode #(
    parameter int AW = 16,
    parameter int LANES = 4,
    parameter int IDX_W = 8,
    parameter logic [AW-1:0] CTRL_ADDR = 16'h0208,
    parameter logic [AW-1:0] STAGE_BASE = 16'h0200,
    parameter logic [AW-1:0] WIN_BASE = 16'h1400
) (
    input  logic [AW-1:0]              host_addr,
    output logic                       ctrl_hit,
    output logic                       stage_hit,
    output logic [$clog2(LANES)-1:0]   lane_sel,
    output logic                       win_hit,
    output logic [IDX_W:0]             win_idx
);
    localparam int LSEL_W      = $clog2(LANES);
    localparam int STAGE_BYTES = 2 * LANES;
    localparam int WIN_BYTES   = 2 ** (IDX_W + 2);

    logic [AW-1:0] stage_off;
    logic [AW-1:0] win_off;

    always_comb begin
        stage_off = host_addr - STAGE_BASE;
        win_off   = host_addr - WIN_BASE;
        ctrl_hit  = (host_addr == CTRL_ADDR);
        stage_hit = (stage_off < AW'(STAGE_BYTES)) && !stage_off[0];
        lane_sel  = stage_off[LSEL_W:1];
        win_hit   = (win_off < AW'(WIN_BYTES));
        win_idx   = win_off[IDX_W+1:1];
    end
endmodule

// File: rtl/mls_stage_regs.sv
module mls_stage_regs #(
    parameter int LANES = 4,
    parameter int LANE_W = 16,
    localparam int LSEL_W = $clog2(LANES),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LSEL_W-1:0] wr_lane,
    input  logic [LANE_W-1:0] wr_data,
    input  logic [LSEL_W-1:0] rd_lane,
    output logic [LANE_W-1:0] rd_data,
    output logic [WORD_W-1:0] word
);
    logic [LANE_W-1:0] lane_q [LANES];

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (!rst_n) begin
                lane_q[k] <= '0;
            end else if (wr_en && (wr_lane == LSEL_W'(k))) begin
                lane_q[k] <= wr_data;
            end
        end
    end

    // Lane 0 occupies the most significant slice of the microword.
    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign word[WORD_W-1-g*LANE_W -: LANE_W] = lane_q[g];
    end

    assign rd_data = lane_q[rd_lane];
endmodule

// File: rtl/mls_store.sv
module mls_store #(
    parameter int ENTRIES = 256,
    parameter int WORD_W = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
        rdata <= mem[ridx];
    end
endmodule

// File: rtl/microstore_loader.sv
module microstore_loader #(
    parameter int AW = 16,
    parameter int LANE_W = 16,
    parameter int LANES = 4,
    parameter int ENTRIES = 256,
    parameter logic [AW-1:0] CTRL_ADDR = 16'h0208,
    parameter logic [AW-1:0] STAGE_BASE = 16'h0200,
    parameter logic [AW-1:0] WIN_BASE = 16'h1400,
    parameter logic [LANE_W-1:0] LOAD_KEY = 16'h0003,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int WORD_W = LANES * LANE_W,
    localparam int LSEL_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     host_addr,
    input  logic [LANE_W-1:0] host_wdata,
    input  logic              host_we,
    output logic [LANE_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]  exe_idx,
    output logic [WORD_W-1:0] exe_word
);
    import mls_pkg::*;

    logic              ctrl_hit;
    logic              stage_hit;
    logic [LSEL_W-1:0] lane_sel;
    logic              win_hit;
    logic [IDX_W:0]    win_idx;
    logic [LANE_W-1:0] stage_rd;
    logic [WORD_W-1:0] stage_word;
    logic              ctrl_wr;
    logic              win_wr;
    logic              store_we;
    logic              oor_set;
    logic              oor_flag;
    logic              load_active;
    logic [IDX_W-1:0]  store_idx;
    mls_state_t        state_q;
    mls_state_t        state_d;

    mls_decode #(
        .AW(AW), .LANES(LANES), .IDX_W(IDX_W),
        .CTRL_ADDR(CTRL_ADDR), .STAGE_BASE(STAGE_BASE), .WIN_BASE(WIN_BASE)
    ) u_decode (
        .host_addr(host_addr),
        .ctrl_hit(ctrl_hit),
        .stage_hit(stage_hit),
        .lane_sel(lane_sel),
        .win_hit(win_hit),
        .win_idx(win_idx)
    );

    mls_stage_regs #(.LANES(LANES), .LANE_W(LANE_W)) u_stage (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(host_we && stage_hit),
        .wr_lane(lane_sel),
        .wr_data(host_wdata),
        .rd_lane(lane_sel),
        .rd_data(stage_rd),
        .word(stage_word)
    );

    assign ctrl_wr   = host_we && ctrl_hit;
    assign win_wr    = host_we && win_hit;
    assign store_idx = win_idx[IDX_W-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_wr && (host_wdata == LOAD_KEY)) state_d = ST_LOAD;
            ST_LOAD: if (ctrl_wr && (host_wdata != LOAD_KEY)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        load_active = 1'b0;
        store_we    = 1'b0;
        oor_set     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: begin
                load_active = 1'b1;
                store_we    = win_wr && !win_idx[IDX_W];
                oor_set     = win_wr && win_idx[IDX_W];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oor_flag <= 1'b0;
        end else if (oor_set) begin
            oor_flag <= 1'b1;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (ctrl_hit) begin
            host_rdata[LANE_W-1] = oor_flag;
            host_rdata[0]        = load_active;
        end else if (stage_hit) begin
            host_rdata = stage_rd;
        end
    end

    mls_store #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_store (
        .clk(clk),
        .we(store_we),
        .widx(store_idx),
        .wdata(stage_word),
        .ridx(exe_idx),
        .rdata(exe_word)
    );
endmodule

// File: rtl/mls_checker.sv
module mls_checker #(
    parameter int AW = 16,
    parameter int LANE_W = 16,
    parameter int WORD_W = 64,
    parameter logic [AW-1:0] CTRL_ADDR = 16'h0208,
    parameter logic [LANE_W-1:0] LOAD_KEY = 16'h0003
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [AW-1:0]     host_addr,
    input logic [LANE_W-1:0] host_wdata,
    input logic              load_active,
    input logic              store_we,
    input logic              oor_flag,
    input logic [WORD_W-1:0] stage_word
);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!load_active && !oor_flag && stage_word == '0));

    a_r3_key_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == CTRL_ADDR && host_wdata == LOAD_KEY) |=> load_active);

    a_r3_other_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == CTRL_ADDR && host_wdata != LOAD_KEY) |=> !load_active);

    a_r6_commit_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> load_active);

    a_r7_stage_kept: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |=> $stable(stage_word));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        oor_flag |=> oor_flag);
endmodule

bind microstore_loader mls_checker #(
    .AW(AW), .LANE_W(LANE_W), .WORD_W(WORD_W),
    .CTRL_ADDR(CTRL_ADDR), .LOAD_KEY(LOAD_KEY)
) u_mls_checker (
    .clk(clk),
    .rst_n(rst_n),
    .host_we(host_we),
    .host_addr(host_addr),
    .host_wdata(host_wdata),
    .load_active(load_active),
    .store_we(store_we),
    .oor_flag(oor_flag),
    .stage_word(stage_word)
);

// File: tb/tb_microstore_loader.sv
module tb_microstore_loader;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] CTRL  = 16'h0208;
    localparam logic [15:0] STAGE = 16'h0200;
    localparam logic [15:0] WIN   = 16'h1400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_we = 1'b0;
    logic [15:0] host_rdata;
    logic [7:0]  exe_idx = '0;
    logic [63:0] exe_word;

    int checks = 0;
    int fails = 0;
    logic [63:0] ref_mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    microstore_loader dut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we),
        .host_rdata(host_rdata), .exe_idx(exe_idx), .exe_word(exe_word)
    );

    function automatic logic [63:0] pat(input int i);
        return {16'(i * 3 + 1), 16'(i) ^ 16'hA5A5, 16'(i * 7) + 16'h1000, ~16'(i)};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0; host_addr = 16'hFFF0;
    endtask

    task automatic hread(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic xread(input int i, output logic [63:0] w);
        @(negedge clk);
        exe_idx = 8'(i);
        @(negedge clk);
        w = exe_word;
    endtask

    task automatic stage_word(input logic [63:0] w);
        for (int k = 0; k < 4; k++) hwrite(STAGE + 16'(2 * k), w[63 - 16 * k -: 16]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        hread(CTRL, d);
        check("R1 ctrl", 64'(d), 64'h0);
        for (int k = 0; k < 4; k++) begin
            hread(STAGE + 16'(2 * k), d);
            check("R1 lane", 64'(d), 64'h0);
        end
    endtask

    task automatic t_stage_rw();
        logic [15:0] d;
        hwrite(STAGE + 16'd4, 16'hBEEF);
        hread(STAGE + 16'd4, d);
        check("R2 lane2", 64'(d), 64'hBEEF);
        hread(STAGE, d);
        check("R2 lane0 untouched", 64'(d), 64'h0);
        stage_word(64'h1111_2222_3333_4444);
        for (int k = 0; k < 4; k++) begin
            hread(STAGE + 16'(2 * k), d);
            check("R2 readback", 64'(d), 64'(16'((k + 1) * 16'h1111)));
        end
    endtask

    task automatic t_mode();
        logic [15:0] d;
        hwrite(CTRL, 16'h0001);
        hread(CTRL, d);
        check("R3 wrong key", 64'(d[0]), 64'h0);
        hwrite(CTRL, 16'h0003);
        hread(CTRL, d);
        check("R3 key enters", 64'(d[0]), 64'h1);
        hwrite(CTRL, 16'h0000);
        hread(CTRL, d);
        check("R3 leave", 64'(d[0]), 64'h0);
    endtask

    task automatic t_full_load();
        logic [63:0] w;
        hwrite(CTRL, 16'h0003);
        for (int i = 0; i < 256; i++) begin
            stage_word(pat(i));
            hwrite(WIN + 16'(2 * i), 16'(i));
            ref_mem[i] = pat(i);
        end
        for (int i = 0; i < 256; i++) begin
            xread(i, w);
            check("R10 R4 entry", w, ref_mem[i]);
        end
    endtask

    task automatic t_data_ignored();
        logic [63:0] w;
        stage_word(64'hCAFE_0123_4567_89AB);
        hwrite(WIN + 16'd6, 16'h0000);
        hwrite(WIN + 16'd8, 16'hFFFF);
        ref_mem[3] = 64'hCAFE_0123_4567_89AB;
        ref_mem[4] = 64'hCAFE_0123_4567_89AB;
        xread(3, w);
        check("R5 data 0000", w, ref_mem[3]);
        xread(4, w);
        check("R5 data FFFF", w, ref_mem[4]);
    endtask

    task automatic t_stage_keep();
        logic [63:0] w;
        logic [15:0] d;
        hread(STAGE + 16'd2, d);
        check("R7 lane kept", 64'(d), 64'h0123);
        hwrite(STAGE + 16'd4, 16'h7777);
        hwrite(WIN + 16'd14, 16'h0);
        ref_mem[7] = 64'hCAFE_0123_7777_89AB;
        xread(7, w);
        check("R7 partial commit", w, ref_mem[7]);
    endtask

    task automatic t_same_cycle();
        logic [63:0] w;
        stage_word(64'h9999_8888_7777_6666);
        @(negedge clk);
        host_addr = WIN + 16'd18; host_wdata = 16'h0; host_we = 1'b1;
        exe_idx = 8'd9;
        @(negedge clk);
        host_we = 1'b0; host_addr = 16'hFFF0;
        check("R9 old word", exe_word, ref_mem[9]);
        ref_mem[9] = 64'h9999_8888_7777_6666;
        @(negedge clk);
        check("R9 new word", exe_word, ref_mem[9]);
        xread(9, w);
        check("R9 latency", w, ref_mem[9]);
    endtask

    task automatic t_idle_commit();
        logic [63:0] w;
        hwrite(CTRL, 16'h0000);
        stage_word(64'hDEAD_DEAD_DEAD_DEAD);
        hwrite(WIN + 16'd10, 16'h5555);
        xread(5, w);
        check("R6 idle commit", w, ref_mem[5]);
    endtask

    task automatic t_out_of_range();
        logic [63:0] w;
        logic [15:0] d;
        hwrite(CTRL, 16'h0003);
        hread(CTRL, d);
        check("R8 flag clear", 64'(d[15]), 64'h0);
        hwrite(WIN + 16'(2 * 300), 16'h0);
        hread(CTRL, d);
        check("R8 flag set", 64'(d[15]), 64'h1);
        xread(44, w);
        check("R8 entry44", w, ref_mem[44]);
        xread(255, w);
        check("R8 entry255", w, ref_mem[255]);
        hwrite(CTRL, 16'h0000);
        hread(CTRL, d);
        check("R8 flag sticky", 64'(d), 64'h8000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        host_addr = 16'hFFF0;
        t_reset();
        t_stage_rw();
        t_mode();
        t_full_load();
        t_data_ignored();
        t_stage_keep();
        t_same_cycle();
        t_idle_commit();
        t_out_of_range();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule